// File: doc/BRIEF.md
# Two-Wire Bus Clock Generator with Edge-Offset Strobes

This block produces the serial clock of a two-wire bus from the core clock. A 16-bit divider sets the clock period. Each period is split into a low half and a high half. Inside each half the block places one strobe. The data-drive strobe fires a programmable number of core cycles after the clock falls; the sequencer changes its data line on it. The data-sample strobe fires a programmable number of core cycles after the clock is seen high; the sequencer captures the data line on it.

The clock output is open-drain in meaning: 1 releases the line, 0 pulls it low. The line as read back from the pad comes in on a separate input. When the line is released but still reads low, a target is stretching the clock. The high-half count then pauses until the line really goes high. A stretch that lasts a programmable number of full clock periods raises a sticky timeout flag, which the sequencer treats as an error.

The sequencer's enable starts and stops the clock. Byte framing, data storage and register access live outside this block.

Top module: `scl_edge_timer`

## Requirements
- R1: While `enable` is low, `sclOut` is 1 (released), both strobes are 0, and `stretchTimeout` is 0 from the first clock edge after `enable` falls.
- R2: With `enable` high and no stretching, `sclOut` alternates a low half and a high half. Each half lasts floor(D/2) core cycles, where D is the effective divider, so an odd divider behaves as the next lower even value. The first half after `enable` rises is the low half.
- R3: A `divider` value of 0 is treated as 32768, which gives halves of 16384 cycles.
- R4: A `divider` value of 1 is treated as 2, which gives halves of one cycle.
- R5: `sdaDriveStb` is high for exactly one cycle in each low half. Counting the first low cycle as index 0, that cycle has index equal to the clamped falling delay.
- R6: `sdaSampleStb` is high for exactly one cycle in each high half. Counting the first cycle in which `sclIn` reads 1 as index 0, that cycle has index equal to the clamped rising delay.
- R7: A delay value of at least floor(D/2) is clamped to floor(D/2) − 1. Smaller values are used as given.
- R8: During a high half, each cycle in which `sclIn` reads 0 is a stretch cycle and does not advance the high-half count. After release, the high half still lasts floor(D/2) cycles.
- R9: With `stretchLimit` = N > 0, a continuous stretch makes `stretchTimeout` read 1 in stretch cycle N·D + 1, counting the first stretch cycle as 0. The flag stays 1 while `enable` stays high, even after the stretch ends.
- R10: With `stretchLimit` = 0, `stretchTimeout` never rises, however long the stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the bus clock while high |
| divider | input | 16 | Core cycles per bus clock period (0 means 32768) |
| fallDelay | input | 16 | Core cycles from clock fall to data-drive strobe |
| riseDelay | input | 16 | Core cycles from seen clock rise to data-sample strobe |
| stretchLimit | input | 16 | Stretch timeout in bus clock periods (0 disables) |
| sclIn | input | 1 | Clock line as read back from the pad |
| sclOut | output | 1 | Clock line drive: 1 releases, 0 pulls low |
| sdaDriveStb | output | 1 | One-cycle strobe to change the data line |
| sdaSampleStb | output | 1 | One-cycle strobe to sample the data line |
| stretchTimeout | output | 1 | Sticky stretch timeout flag |

## Verification
The bench builds the block with its default 16-bit widths for the divider, the delays and the timeout. This lets it apply the zero-divider case and measure the full 16384-cycle low half within the run. Small dividers (1, 4, 8, 10, 11) put the clamp limit, the odd-divider rounding and the delay-at-boundary cases only a few cycles apart. A divider of 4 with a timeout of three periods places the timeout edge at a known cycle of a held-low line. The read-back line is modelled as the clock drive ANDed with a target hold signal, so stretches of chosen length can be injected.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  // Commands from the control FSM to the counting datapath.
  typedef struct packed {
    logic clrPhase;   // restart the half-period counter
    logic advPhase;   // advance the half-period counter
    logic stretching; // line released but held low by a target
  } phaseCmd_t;

  // Compare results from the datapath back to the control FSM.
  typedef struct packed {
    logic halfEnd;      // counter at last cycle of a half
    logic atFall;       // counter equals clamped falling delay
    logic atRise;       // counter equals clamped rising delay
    logic limitReached; // stretch has lasted the programmed periods
  } phaseStat_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

endpackage

// File: rtl/sclgen_datapath.sv
module sclgen_datapath
  import sclgen_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divider,
  input  logic [DLY_W-1:0] fallDelay,
  input  logic [DLY_W-1:0] riseDelay,
  input  logic [TMO_W-1:0] stretchLimit,
  input  phaseCmd_t        cmd,
  output phaseStat_t       stat
);

  localparam logic [DIV_W-1:0] ZERO_DIV = {1'b1, {(DIV_W-1){1'b0}}};
  localparam logic [DIV_W-1:0] MIN_DIV  = DIV_W'(2);

  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] halfLen;
  logic [DIV_W-1:0] halfM1;
  logic [DIV_W-1:0] fallClamp;
  logic [DIV_W-1:0] riseClamp;
  logic [DIV_W-1:0] phaseCnt;
  logic [DIV_W-1:0] periodCnt;
  logic [TMO_W-1:0] stretchCnt;
  logic             periodWrap;

  // Divider normalisation: 0 stands for the largest period, 1 for the smallest.
  always_comb begin
    if (divider == '0)
      effDiv = ZERO_DIV;
    else if (divider < MIN_DIV)
      effDiv = MIN_DIV;
    else
      effDiv = divider;
    halfLen = {1'b0, effDiv[DIV_W-1:1]};
    halfM1  = halfLen - DIV_W'(1);
  end

  // Edge offsets are held strictly inside their half period.
  function automatic logic [DIV_W-1:0] clampDelay(input logic [DLY_W-1:0] d,
                                                  input logic [DIV_W-1:0] lim);
    if ((DIV_W)'(d) > lim) return lim;
    return (DIV_W)'(d);
  endfunction

  assign fallClamp = clampDelay(fallDelay, halfM1);
  assign riseClamp = clampDelay(riseDelay, halfM1);

  // Half-period counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (cmd.clrPhase)
      phaseCnt <= '0;
    else if (cmd.advPhase)
      phaseCnt <= phaseCnt + DIV_W'(1);
  end

  // Stretch timing: full bus periods are counted while the line is held low.
  assign periodWrap = (periodCnt == effDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt  <= '0;
      stretchCnt <= '0;
    end else if (!cmd.stretching) begin
      periodCnt  <= '0;
      stretchCnt <= '0;
    end else begin
      periodCnt <= periodWrap ? '0 : periodCnt + DIV_W'(1);
      if (periodWrap && stretchCnt != stretchLimit)
        stretchCnt <= stretchCnt + TMO_W'(1);
    end
  end

  always_comb begin
    stat.halfEnd      = (phaseCnt == halfM1);
    stat.atFall       = (phaseCnt == fallClamp);
    stat.atRise       = (phaseCnt == riseClamp);
    stat.limitReached = (stretchLimit != '0) && (stretchCnt == stretchLimit);
  end

  // R8: a stretch cycle leaves the half-period count untouched.
  a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stretching |=> $stable(phaseCnt));

  // R9: leaving a stretch discards the accumulated stretch periods.
  a_r9_stretch_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.stretching |=> (stretchCnt == '0));

endmodule

// File: rtl/sclgen_control.sv
module sclgen_control
  import sclgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sclIn,
  input  phaseStat_t stat,
  output phaseCmd_t  cmd,
  output logic       sclOut,
  output logic       sdaDriveStb,
  output logic       sdaSampleStb,
  output logic       stretchTimeout
);

  phase_t phase;

  // Command decode for the datapath.
  always_comb begin
    cmd = '0;
    if (!enable) begin
      cmd.clrPhase = 1'b1;
    end else begin
      unique case (phase)
        PH_LOW: begin
          if (stat.halfEnd) cmd.clrPhase = 1'b1;
          else              cmd.advPhase = 1'b1;
        end
        PH_HIGH: begin
          if (!sclIn)            cmd.stretching = 1'b1;
          else if (stat.halfEnd) cmd.clrPhase   = 1'b1;
          else                   cmd.advPhase   = 1'b1;
        end
        default: cmd.clrPhase = 1'b1;
      endcase
    end
  end

  // Phase sequencing and clock drive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      sclOut <= 1'b1;
    end else if (!enable) begin
      phase  <= PH_IDLE;
      sclOut <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase  <= PH_LOW;
          sclOut <= 1'b0;
        end
        PH_LOW: begin
          if (stat.halfEnd) begin
            phase  <= PH_HIGH;
            sclOut <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (sclIn && stat.halfEnd) begin
            phase  <= PH_LOW;
            sclOut <= 1'b0;
          end
        end
        default: begin
          phase  <= PH_IDLE;
          sclOut <= 1'b1;
        end
      endcase
    end
  end

  // Sticky timeout, cleared only by dropping enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      stretchTimeout <= 1'b0;
    else if (!enable)
      stretchTimeout <= 1'b0;
    else if (stat.limitReached)
      stretchTimeout <= 1'b1;
  end

  assign sdaDriveStb  = enable && (phase == PH_LOW) && stat.atFall;
  assign sdaSampleStb = enable && (phase == PH_HIGH) && sclIn && stat.atRise;

  // R1: a disabled block releases the line and clears the flag.
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !stretchTimeout));

  // R2: the end of a low half releases the line on the next edge.
  a_r2_low_to_high: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_LOW && stat.halfEnd) |=> sclOut);

  // R5: the drive strobe only falls inside a low half.
  a_r5_drive_in_low: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveStb |-> !sclOut);

  // R6: the sample strobe only falls while the line is seen high.
  a_r6_sample_when_high: assert property (@(posedge clk) disable iff (!rstN)
    sdaSampleStb |-> (sclOut && sclIn));

  // R9: the flag holds while enabled, and only rises after the limit was met.
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (enable && stretchTimeout) |=> stretchTimeout);

  a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stretchTimeout) |-> $past(stat.limitReached));

endmodule

// File: rtl/scl_edge_timer.sv
module scl_edge_timer
  import sclgen_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divider,
  input  logic [DLY_W-1:0] fallDelay,
  input  logic [DLY_W-1:0] riseDelay,
  input  logic [TMO_W-1:0] stretchLimit,
  input  logic             sclIn,
  output logic             sclOut,
  output logic             sdaDriveStb,
  output logic             sdaSampleStb,
  output logic             stretchTimeout
);

  phaseCmd_t  cmd;
  phaseStat_t stat;

  sclgen_datapath #(
    .DIV_W(DIV_W),
    .DLY_W(DLY_W),
    .TMO_W(TMO_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .divider      (divider),
    .fallDelay    (fallDelay),
    .riseDelay    (riseDelay),
    .stretchLimit (stretchLimit),
    .cmd          (cmd),
    .stat         (stat)
  );

  sclgen_control u_control (
    .clk            (clk),
    .rstN           (rstN),
    .enable         (enable),
    .sclIn          (sclIn),
    .stat           (stat),
    .cmd            (cmd),
    .sclOut         (sclOut),
    .sdaDriveStb    (sdaDriveStb),
    .sdaSampleStb   (sdaSampleStb),
    .stretchTimeout (stretchTimeout)
  );

endmodule

// File: tb/scl_edge_timer_tb.sv
module scl_edge_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] divider = 16'd10;
  logic [15:0] fallDelay = '0;
  logic [15:0] riseDelay = '0;
  logic [15:0] stretchLimit = '0;
  logic        hold = 1'b0;
  logic        sclIn;
  logic        sclOut;
  logic        sdaDriveStb;
  logic        sdaSampleStb;
  logic        stretchTimeout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // Open-drain line: the target may hold it low.
  assign sclIn = sclOut & ~hold;

  scl_edge_timer u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .enable         (enable),
    .divider        (divider),
    .fallDelay      (fallDelay),
    .riseDelay      (riseDelay),
    .stretchLimit   (stretchLimit),
    .sclIn          (sclIn),
    .sclOut         (sclOut),
    .sdaDriveStb    (sdaDriveStb),
    .sdaSampleStb   (sdaSampleStb),
    .stretchTimeout (stretchTimeout)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stop_clock();
    @(negedge clk);
    enable = 1'b0;
    hold   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Measures one low half and the following high half, starting from the next fall.
  task automatic measure(output int lowLen, output int highLen, output int fallIdx,
                         output int riseIdx, output int nFall, output int nRise);
    int guard;
    lowLen = 0; highLen = 0; fallIdx = -1; riseIdx = -1; nFall = 0; nRise = 0;
    guard = 0;
    while (sclOut !== 1'b0 && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
    while (sclOut === 1'b0 && lowLen < 70000) begin
      if (sdaDriveStb) begin fallIdx = lowLen; nFall++; end
      lowLen++;
      @(negedge clk);
    end
    while (sclOut === 1'b1 && highLen < 70000) begin
      if (sdaSampleStb) begin riseIdx = highLen; nRise++; end
      highLen++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input string req, input logic [15:0] div,
                          input logic [15:0] fd, input logic [15:0] rd,
                          input int expHalf, input int expFall, input int expRise);
    int lo, hi, fi, ri, nf, nr;
    @(negedge clk);
    divider = div; fallDelay = fd; riseDelay = rd; stretchLimit = '0;
    enable = 1'b1;
    measure(lo, hi, fi, ri, nf, nr);
    chk(req, "low half length", lo, expHalf);
    chk(req, "high half length", hi, expHalf);
    chk(req, "drive strobe index", fi, expFall);
    chk(req, "sample strobe index", ri, expRise);
    chk(req, "drive strobes per half", nf, 1);
    chk(req, "sample strobes per half", nr, 1);
    stop_clock();
  endtask

  // R1: reset and idle state.
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "sclOut in reset", int'(sclOut), 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "sclOut idle", int'(sclOut), 1);
    chk("R1", "drive strobe idle", int'(sdaDriveStb), 0);
    chk("R1", "sample strobe idle", int'(sdaSampleStb), 0);
    chk("R1", "timeout idle", int'(stretchTimeout), 0);
  endtask

  // R2, R5, R6: regular timing; R7 clamp; R4 tiny divider; R2 odd divider.
  task automatic t_timing();
    run_case("R2", 16'd10, 16'd2, 16'd3, 5, 2, 3);
    run_case("R5", 16'd8, 16'd0, 16'd3, 4, 0, 3);
    run_case("R7", 16'd10, 16'd9, 16'd5, 5, 4, 4);
    run_case("R7", 16'd12, 16'd5, 16'd6, 6, 5, 5);
    run_case("R4", 16'd1, 16'd3, 16'd0, 1, 0, 0);
    run_case("R2", 16'd11, 16'd1, 16'd4, 5, 1, 4);
  endtask

  // R3: zero divider gives 16384-cycle halves.
  task automatic t_zero_div();
    run_case("R3", 16'd0, 16'd100, 16'd16383, 16384, 100, 16383);
  endtask

  // R8 stretch with R10 zero limit.
  task automatic t_stretch();
    int idx, ri;
    @(negedge clk);
    divider = 16'd10; fallDelay = 16'd1; riseDelay = 16'd2; stretchLimit = '0;
    enable = 1'b1;
    while (sclOut !== 1'b0) @(negedge clk);
    hold = 1'b1;
    while (sclOut !== 1'b1) @(negedge clk);
    idx = 0; ri = -1;
    while (sclOut === 1'b1 && idx < 1000) begin
      if (idx == 37) begin hold = 1'b0; #1; end
      if (sdaSampleStb) ri = idx;
      if (stretchTimeout) begin
        chk("R10", "timeout with zero limit", 1, 0);
      end
      idx++;
      @(negedge clk);
    end
    chk("R8", "stretched high length", idx, 42);
    chk("R8", "sample index after release", ri, 39);
    chk("R10", "timeout after long stretch, zero limit", int'(stretchTimeout), 0);
    stop_clock();
  endtask

  // R9: timeout timing, stickiness, clear by disable.
  task automatic t_timeout();
    int idx;
    @(negedge clk);
    divider = 16'd4; fallDelay = '0; riseDelay = '0; stretchLimit = 16'd3;
    enable = 1'b1;
    while (sclOut !== 1'b0) @(negedge clk);
    hold = 1'b1;
    while (sclOut !== 1'b1) @(negedge clk);
    idx = 0;
    while (!stretchTimeout && idx < 200) begin
      idx++;
      @(negedge clk);
    end
    chk("R9", "timeout cycle in stretch", idx, 13);
    hold = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9", "timeout sticky after release", int'(stretchTimeout), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R9", "timeout cleared by disable", int'(stretchTimeout), 0);
    chk("R1", "sclOut released on disable", int'(sclOut), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_zero_div();
    t_stretch();
    t_timeout();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule